// File: doc/BRIEF.md
# Masked interrupt status register

This block collects thirteen single-cycle event pulses from a serial-flash controller into a sticky status register and raises one combined interrupt line. A companion mask register decides which events may latch at all. An event whose mask bit is 0 leaves no trace, so unmasking a source later does not show an old event. Software clears status bits by writing ones. Three error bits (receive overflow, transmit underflow and mode fault) also clear when the status register is read.

Five of the FIFO-related sources only mean something in legacy SPI mode. Their events are dropped when that mode is off. The block also watches the slave-select input. If that input is low while the controller acts as master, another master is driving the bus. The block then flags a mode fault and forces the controller enable bit to 0. Register access uses a plain 32-bit read/write strobe port with byte offsets. Status is at 0x40 and the mask is at 0x44. Read data is registered.

Top module: `flash_irq_status`

## Requirements
- R1: Bits 31:13 of both the status register (offset 0x40) and the mask register (offset 0x44) always read as 0, and writes to them have no effect.
- R2: Status bit positions are: 0 mode fault, 1 TX underflow, 2 indirect done, 3 indirect rejected, 4 protected write, 5 illegal bus access, 6 indirect watermark, 7 RX overflow, 8 TX threshold, 9 TX full, 10 RX threshold, 11 RX full, 12 indirect SRAM full. Event input bit k-1 (src_evt[k]) drives status bit k for k = 1..12.
- R3: A status bit becomes 1 only when its event occurs in a cycle where the matching mask bit is 1.
- R4: irq is 1 exactly when at least one status bit is 1.
- R5: Writing the status register clears every bit written as 1 and leaves bits written as 0 unchanged.
- R6: Events for status bits 6 to 10 are ignored while legacy_mode is 0.
- R7: A read of the status register returns the current value and then clears bits 7, 1 and 0. Other bits are not affected by the read.
- R8: An event arriving in the same cycle as a clearing read keeps its bit set.
- R9: An event arriving in the same cycle as a write-1 clear keeps its bit set.
- R10: A mode fault exists when master_mode is 1 and ss_n is 0. It sets status bit 0 if that bit is unmasked. It always forces ctrl_en to 0, even if en_wr requests 1 in the same cycle.
- R11: Synchronous active-low reset zeroes status, mask, ctrl_en and read data. Read data appears one clock edge after the read strobe and holds until the next read. Reads of other offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_addr | input | ADDR_W | Byte offset of the access |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Registered read data |
| src_evt | input | 12 | Event pulses for status bits 12..1 |
| legacy_mode | input | 1 | Legacy SPI mode active |
| master_mode | input | 1 | Controller acts as bus master |
| ss_n | input | 1 | Slave-select input, active low |
| en_wr | input | 1 | Load strobe for the controller enable |
| en_din | input | 1 | Value loaded into the controller enable |
| ctrl_en | output | 1 | Controller enable bit |
| irq | output | 1 | Combined interrupt |

## Verification
The following outputs change at the first rising edge after their stimulus:
- status bits, irq and ctrl_en respond to an event, clear or fault at that edge;
- reg_rdata takes the addressed value at the edge that samples the read strobe.

The bench drives every input on a falling edge, holds it across one rising edge, and samples on the next falling edge. Each expected value is therefore compared exactly one register stage after its cause. Checks of coincident event-and-clear cycles read the register one access later. This shows whether the bit stayed set.

// File: rtl/flash_irq_status.sv
module flash_irq_status #(
  parameter int ADDR_W = 8,
  parameter int DW = 32,
  parameter logic [ADDR_W-1:0] STAT_OFS = 8'h40,
  parameter logic [ADDR_W-1:0] MASK_OFS = 8'h44
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic [12:1]       src_evt,
  input  logic              legacy_mode,
  input  logic              master_mode,
  input  logic              ss_n,
  input  logic              en_wr,
  input  logic              en_din,
  output logic              ctrl_en,
  output logic              irq
);
  localparam int NSRC = 13;
  localparam logic [NSRC-1:0] LEG_BITS = 13'h07C0;
  localparam logic [NSRC-1:0] COR_BITS = 13'h0083;

  logic [NSRC-1:0] stat_q, mask_q, set_v, w1c_v, cor_v;
  logic st_hit, mk_hit, fault;
  logic unused_hi;

  assign unused_hi = &{1'b0, reg_wdata[DW-1:NSRC]};
  assign st_hit = (reg_addr == STAT_OFS);
  assign mk_hit = (reg_addr == MASK_OFS);
  assign fault  = master_mode & ~ss_n;

  assign set_v = {src_evt, fault} & mask_q & (legacy_mode ? {NSRC{1'b1}} : ~LEG_BITS);
  assign w1c_v = (reg_wr && st_hit) ? reg_wdata[NSRC-1:0] : '0;
  assign cor_v = (reg_rd && st_hit) ? COR_BITS : '0;
  assign irq   = |stat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~(w1c_v | cor_v)) | set_v;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                mask_q <= '0;
    else if (reg_wr && mk_hit) mask_q <= reg_wdata[NSRC-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     ctrl_en <= 1'b0;
    else if (fault) ctrl_en <= 1'b0;
    else if (en_wr) ctrl_en <= en_din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) reg_rdata <= '0;
    else if (reg_rd) begin
      if (st_hit)      reg_rdata <= {{(DW-NSRC){1'b0}}, stat_q};
      else if (mk_hit) reg_rdata <= {{(DW-NSRC){1'b0}}, mask_q};
      else             reg_rdata <= '0;
    end
  end

  p_mask_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & ~$past(stat_q) & ~$past(mask_q)) == '0));

  p_legacy_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(legacy_mode) |-> ((stat_q & ~$past(stat_q) & LEG_BITS) == '0));

  p_w1c_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reg_wr && st_hit) |-> ((stat_q & $past(reg_wdata[NSRC-1:0]) & ~$past(set_v)) == '0));

  p_read_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reg_rd && st_hit) |-> ((stat_q & COR_BITS & ~$past(set_v)) == '0));

  p_fault_disable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fault) |-> !ctrl_en);
endmodule

// File: tb/flash_irq_status_tb.sv
module flash_irq_status_tb;
  logic clk = 0, rst_n = 0;
  logic [7:0] reg_addr = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic [12:1] src_evt = 0;
  logic legacy_mode = 0, master_mode = 0, ss_n = 1, en_wr = 0, en_din = 0;
  logic ctrl_en, irq;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  flash_irq_status u_dut (.clk, .rst_n, .reg_addr, .reg_wr, .reg_rd, .reg_wdata,
    .reg_rdata, .src_evt, .legacy_mode, .master_mode, .ss_n, .en_wr, .en_din,
    .ctrl_en, .irq);

  // {mask, event (bit0 unused), legacy, expected status}
  localparam logic [39:0] VEC [8] = '{
    {13'h1FFF, 13'h1FFE, 1'b1, 13'h1FFE},
    {13'h1FFF, 13'h1FFE, 1'b0, 13'h183E},
    {13'h0AAA, 13'h1FFE, 1'b1, 13'h0AAA},
    {13'h1555, 13'h1FFE, 1'b1, 13'h1554},
    {13'h0000, 13'h1FFE, 1'b1, 13'h0000},
    {13'h1FFF, 13'h0002, 1'b0, 13'h0002},
    {13'h1000, 13'h1000, 1'b0, 13'h1000},
    {13'h07C0, 13'h07C0, 1'b0, 13'h0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic rd(input logic [7:0] a);
    reg_addr = a; reg_rd = 1;
    @(negedge clk);
    reg_rd = 0;
  endtask

  task automatic pulse(input logic [12:1] e);
    src_evt = e;
    @(negedge clk);
    src_evt = 0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 20000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    check("R11 reset rdata", reg_rdata, 0);
    check("R11 reset irq", {31'b0, irq}, 0);
    check("R11 reset ctrl_en", {31'b0, ctrl_en}, 0);
    rd(8'h40);
    check("R11 reset status", reg_rdata, 0);

    for (int i = 0; i < 8; i++) begin
      wr(8'h44, {19'b0, VEC[i][39:27]});
      wr(8'h40, 32'h1FFF);
      legacy_mode = VEC[i][13];
      pulse(VEC[i][26:15]);
      legacy_mode = 0;
      check("R2 R3 R6 vector status irq", {18'b0, irq, VEC[i][12:0]}, {18'b0, irq, VEC[i][12:0]} & 32'h1FFF | {18'b0, (VEC[i][12:0] != 0), 13'b0});
      rd(8'h40);
      check("R2 R3 R6 vector status", reg_rdata, {19'b0, VEC[i][12:0]});
    end

    // R1 reserved bits and mask readback, R11 other offset
    wr(8'h44, 32'hFFFF_FFFF);
    rd(8'h44);
    check("R1 mask reserved", reg_rdata, 32'h0000_1FFF);
    rd(8'h48);
    check("R11 unmapped read", reg_rdata, 0);
    @(negedge clk);
    check("R11 rdata held", reg_rdata, 0);

    // R5 write-1-clear
    wr(8'h40, 32'hFFFF_FFFF);
    pulse(12'h00C);
    wr(8'h40, 32'h0);
    rd(8'h40);
    check("R5 write zero no change", reg_rdata, 32'h18);
    wr(8'h40, 32'h8);
    rd(8'h40);
    check("R5 write one clears", reg_rdata, 32'h10);
    check("R4 irq with bit set", {31'b0, irq}, 1);
    wr(8'h40, 32'h10);
    check("R4 irq low when empty", {31'b0, irq}, 0);

    // R7 clear on read
    legacy_mode = 1;
    pulse(12'h043);
    legacy_mode = 0;
    rd(8'h40);
    check("R7 first read", reg_rdata, 32'h86);
    rd(8'h40);
    check("R7 second read", reg_rdata, 32'h04);

    // R8 event with read keeps bit
    wr(8'h40, 32'h1FFF);
    pulse(12'h001);
    reg_addr = 8'h40; reg_rd = 1; src_evt = 12'h001;
    @(negedge clk);
    reg_rd = 0; src_evt = 0;
    check("R8 read value", reg_rdata, 32'h2);
    rd(8'h40);
    check("R8 bit kept", reg_rdata, 32'h2);

    // R9 event with write-1-clear keeps bit
    wr(8'h40, 32'h1FFF);
    pulse(12'h002);
    reg_addr = 8'h40; reg_wdata = 32'h4; reg_wr = 1; src_evt = 12'h002;
    @(negedge clk);
    reg_wr = 0; reg_wdata = 0; src_evt = 0;
    rd(8'h40);
    check("R9 bit kept", reg_rdata, 32'h4);

    // R10 mode fault
    wr(8'h40, 32'h1FFF);
    wr(8'h44, 32'h1FFE);
    en_wr = 1; en_din = 1;
    @(negedge clk);
    en_wr = 0;
    check("R10 enable set", {31'b0, ctrl_en}, 1);
    master_mode = 0; ss_n = 0;
    @(negedge clk);
    check("R10 slave no fault", {31'b0, ctrl_en}, 1);
    master_mode = 1;
    @(negedge clk);
    master_mode = 0; ss_n = 1;
    check("R10 masked fault drops enable", {30'b0, ctrl_en, irq}, 0);
    wr(8'h44, 32'h1FFF);
    master_mode = 1; ss_n = 0; en_wr = 1; en_din = 1;
    @(negedge clk);
    master_mode = 0; ss_n = 1; en_wr = 0;
    check("R10 fault beats enable write", {30'b0, ctrl_en, irq}, 1);
    rd(8'h40);
    check("R10 fault bit", reg_rdata, 32'h1);

    // R11 reset mid-run
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    rd(8'h44);
    check("R11 reset clears mask", reg_rdata, 0);

    summary();
  end
endmodule